// File: doc/BRIEF.md
# Edge-Detecting GPIO Controller

This block is a 64-pin general-purpose I/O controller reached through a plain 32-bit memory-mapped read/write port. The pins are grouped into two banks of 32. Each pin has an output-enable bit, an output latch, and a synchronized input level that software can read back. Each pin also has independent rising-edge and falling-edge detect enables. Software changes the output latch only through write-1-to-set and write-1-to-clear words, so no read-modify-write is needed to drive a single pin.

When an enabled edge is detected, it sets a sticky status bit. Software clears that bit by writing 1 to it. The OR of all status bits forms one level-type interrupt request. Each pin also carries a 2-bit alternate-function selector. The selectors are packed 16 pins to a word and exported on a port for the pad multiplexing logic, which lies outside this block.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Word index is bus_addr[6:2]. Accesses with bus_addr[1:0] != 0, and word indices 18 to 31, read as 0 and change nothing. Writes to the level words (indices 0 and 1) change nothing. Reads of the set and clear words (indices 4 to 7) return 0.
- R2: The direction words (index 2 for bank 0, index 3 for bank 1) are read/write. A bit value of 1 makes the pin an output. pin_oe[n] follows the stored bit one cycle after the write.
- R3: The level words (index 0 for pins 0 to 31, index 1 for pins 32 to 63) return pin_in through a two-flop synchronizer. A change on pin_in is readable after the second rising clock edge.
- R4: Writing the set word (index 4 or 5) drives pin_out high for every bit written as 1, from the next cycle. Bits written as 0 keep their value.
- R5: Writing the clear word (index 6 or 7) drives pin_out low for every bit written as 1, from the next cycle. Bits written as 0 keep their value.
- R6: With the pin's rising enable set (word index 8 or 9), a 0-to-1 change on pin_in sets that pin's status bit (word index 12 or 13) at the third rising edge after the change.
- R7: With the falling enable set (word index 10 or 11), a 1-to-0 change sets the status bit in the same way. With both enables set, both edges are detected. With neither set, no status bit is set.
- R8: A status bit stays set until a 1 is written to it. Writing 0 to a status bit leaves it unchanged.
- R9: When an enabled edge and a write-1-to-clear of the same status bit fall in the same cycle, the bit stays 1.
- R10: irq is high exactly while any status bit is set.
- R11: Pin n's alternate-function field is bits [2*(n%16)+1 : 2*(n%16)] of word 14+n/16. The field is readable, and it drives alt_sel[2n+1:2n] from the cycle after the write.
- R12: After reset, every register reads 0: all pins are inputs, the output latches are 0, all enables are clear, no status bit is set, the alternate functions are 0, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current state |
| pin_in | input | 64 | Asynchronous pin inputs |
| pin_out | output | 64 | Output latches |
| pin_oe | output | 64 | Output enables (1 = drive) |
| alt_sel | output | 128 | Packed 2-bit alternate-function selectors |
| irq | output | 1 | Level interrupt request |

## Verification
Register writes take effect at the rising edge that samples them. pin_out, pin_oe and alt_sel are therefore checked one cycle after a write. Reads are combinational and are sampled mid-cycle. A pin_in change becomes readable as a level at the second rising edge and reaches the status bits and irq at the third. The bench drives pin_in at a falling edge and samples after exactly two or three further falling edges. For the same-cycle collision, the clear write is placed so that it is sampled at that third edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int GRP_LVL   = 0;
  localparam int GRP_DIR   = 1;
  localparam int GRP_SET   = 2;
  localparam int GRP_CLR   = 3;
  localparam int GRP_REN   = 4;
  localparam int GRP_FEN   = 5;
  localparam int GRP_STS   = 6;
  localparam int GRP_COUNT = 7;
endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl  = sync_q;
  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] wdata,
  input  logic         dir_we,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic         ren_we,
  input  logic         fen_we,
  input  logic         sts_we,
  output logic [W-1:0] lvl,
  output logic [W-1:0] dir,
  output logic [W-1:0] out,
  output logic [W-1:0] ren,
  output logic [W-1:0] fen,
  output logic [W-1:0] sts
);
  logic [W-1:0] dir_q, out_q, ren_q, fen_q, sts_q;
  logic [W-1:0] out_d, sts_d;
  logic [W-1:0] rise, fall, hit, set_m, clr_m, ack_m;
  logic         out_en, sts_en;

  gpio_sync_edge #(.W(W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_in),
    .lvl  (lvl),
    .rise (rise),
    .fall (fall)
  );

  always_comb begin
    set_m  = set_we ? wdata : '0;
    clr_m  = clr_we ? wdata : '0;
    ack_m  = sts_we ? wdata : '0;
    hit    = (rise & ren_q) | (fall & fen_q);
    out_d  = (out_q | set_m) & ~clr_m;
    out_en = set_we | clr_we;
    // a fresh edge outranks a same-cycle acknowledge (R9)
    sts_d  = (sts_q & ~ack_m) | hit;
    sts_en = sts_we | (|hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      ren_q <= '0;
      fen_q <= '0;
      sts_q <= '0;
    end else begin
      if (dir_we) dir_q <= wdata;
      if (out_en) out_q <= out_d;
      if (ren_we) ren_q <= wdata;
      if (fen_we) fen_q <= wdata;
      if (sts_en) sts_q <= sts_d;
    end
  end

  assign dir = dir_q;
  assign out = out_q;
  assign ren = ren_q;
  assign fen = fen_q;
  assign sts = sts_q;
endmodule

// File: rtl/gpio_altfn.sv
module gpio_altfn #(
  parameter int NWORDS = 4,
  parameter int W      = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NWORDS-1:0]   we,
  input  logic [W-1:0]        wdata,
  output logic [NWORDS*W-1:0] map
);
  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    logic [W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word_q <= '0;
      else if (we[i]) word_q <= wdata;
    end
    assign map[i*W +: W] = word_q;
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int BUS_W    = 32,
  parameter int AF_W     = 2,
  parameter int ADDR_W   = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [BUS_W-1:0]         bus_wdata,
  output logic [BUS_W-1:0]         bus_rdata,
  input  logic [NUM_PINS-1:0]      pin_in,
  output logic [NUM_PINS-1:0]      pin_out,
  output logic [NUM_PINS-1:0]      pin_oe,
  output logic [NUM_PINS*AF_W-1:0] alt_sel,
  output logic                     irq
);
  localparam int NBANK   = NUM_PINS / BUS_W;
  localparam int NAF     = NUM_PINS * AF_W / BUS_W;
  localparam int WIDX_W  = ADDR_W - 2;
  localparam int AF_BASE = GRP_COUNT * NBANK;

  logic [WIDX_W-1:0] word_idx;
  logic              aligned, wr_en;
  logic [NBANK-1:0]  dir_we, set_we, clr_we, ren_we, fen_we, sts_we;
  logic [NAF-1:0]    af_we;
  logic [BUS_W-1:0]  lvl_w [NBANK];
  logic [BUS_W-1:0]  dir_w [NBANK];
  logic [BUS_W-1:0]  ren_w [NBANK];
  logic [BUS_W-1:0]  fen_w [NBANK];
  logic [BUS_W-1:0]  sts_w [NBANK];
  logic [NUM_PINS-1:0] sts_all, en_all;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign wr_en    = bus_sel & bus_wr & aligned;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign dir_we[b] = wr_en && (word_idx == WIDX_W'(GRP_DIR*NBANK + b));
    assign set_we[b] = wr_en && (word_idx == WIDX_W'(GRP_SET*NBANK + b));
    assign clr_we[b] = wr_en && (word_idx == WIDX_W'(GRP_CLR*NBANK + b));
    assign ren_we[b] = wr_en && (word_idx == WIDX_W'(GRP_REN*NBANK + b));
    assign fen_we[b] = wr_en && (word_idx == WIDX_W'(GRP_FEN*NBANK + b));
    assign sts_we[b] = wr_en && (word_idx == WIDX_W'(GRP_STS*NBANK + b));

    logic [BUS_W-1:0] out_b;

    gpio_bank #(.W(BUS_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_in(pin_in[b*BUS_W +: BUS_W]),
      .wdata (bus_wdata),
      .dir_we(dir_we[b]),
      .set_we(set_we[b]),
      .clr_we(clr_we[b]),
      .ren_we(ren_we[b]),
      .fen_we(fen_we[b]),
      .sts_we(sts_we[b]),
      .lvl   (lvl_w[b]),
      .dir   (dir_w[b]),
      .out   (out_b),
      .ren   (ren_w[b]),
      .fen   (fen_w[b]),
      .sts   (sts_w[b])
    );

    assign pin_out[b*BUS_W +: BUS_W] = out_b;
    assign pin_oe [b*BUS_W +: BUS_W] = dir_w[b];
    assign sts_all[b*BUS_W +: BUS_W] = sts_w[b];
    assign en_all [b*BUS_W +: BUS_W] = ren_w[b] | fen_w[b];
  end

  for (genvar a = 0; a < NAF; a++) begin : g_afdec
    assign af_we[a] = wr_en && (word_idx == WIDX_W'(AF_BASE + a));
  end

  gpio_altfn #(.NWORDS(NAF), .W(BUS_W)) u_altfn (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (af_we),
    .wdata(bus_wdata),
    .map  (alt_sel)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && aligned) begin
      for (int b = 0; b < NBANK; b++) begin
        if (word_idx == WIDX_W'(GRP_LVL*NBANK + b)) bus_rdata = lvl_w[b];
        if (word_idx == WIDX_W'(GRP_DIR*NBANK + b)) bus_rdata = dir_w[b];
        if (word_idx == WIDX_W'(GRP_REN*NBANK + b)) bus_rdata = ren_w[b];
        if (word_idx == WIDX_W'(GRP_FEN*NBANK + b)) bus_rdata = fen_w[b];
        if (word_idx == WIDX_W'(GRP_STS*NBANK + b)) bus_rdata = sts_w[b];
      end
      for (int a = 0; a < NAF; a++) begin
        if (word_idx == WIDX_W'(AF_BASE + a)) bus_rdata = alt_sel[a*BUS_W +: BUS_W];
      end
    end
  end

  assign irq = |sts_all;
endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int BUS_W    = 32,
  parameter int AF_W     = 2,
  parameter int WIDX_W   = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [WIDX_W-1:0]        word,
  input logic [BUS_W-1:0]         wdata,
  input logic [NUM_PINS-1:0]      pin_out,
  input logic [NUM_PINS-1:0]      pin_oe,
  input logic [NUM_PINS*AF_W-1:0] alt_sel,
  input logic [NUM_PINS-1:0]      sts_all,
  input logic [NUM_PINS-1:0]      en_all,
  input logic                     irq
);
  localparam int NBANK = NUM_PINS / BUS_W;
  localparam int STS0  = GRP_STS * NBANK;
  localparam int AF0   = GRP_COUNT * NBANK;

  logic ack_wr;
  assign ack_wr = wr_en && (word >= WIDX_W'(STS0)) && (word < WIDX_W'(STS0 + NBANK));

  a_r2_oe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == WIDX_W'(GRP_DIR*NBANK)) |=> pin_oe[BUS_W-1:0] == $past(wdata));

  a_r4_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == WIDX_W'(GRP_SET*NBANK)) |=>
      (pin_out[BUS_W-1:0] & $past(wdata)) == $past(wdata));

  a_r5_clr_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == WIDX_W'(GRP_CLR*NBANK + 1)) |=>
      (pin_out[NUM_PINS-1:BUS_W] & $past(wdata)) == '0);

  a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_wr |=> (sts_all & $past(sts_all)) == $past(sts_all));

  a_r10_irq_drop_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(ack_wr));

  a_r7_no_edge_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|en_all));

  a_r11_altfn_port: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == WIDX_W'(AF0)) |=> alt_sel[BUS_W-1:0] == $past(wdata));
endmodule

bind gpio_edge_ctrl gpio_edge_chk #(
  .NUM_PINS(NUM_PINS),
  .BUS_W   (BUS_W),
  .AF_W    (AF_W),
  .WIDX_W  (ADDR_W - 2)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .word   (word_idx),
  .wdata  (bus_wdata),
  .pin_out(pin_out),
  .pin_oe (pin_oe),
  .alt_sel(alt_sel),
  .sts_all(sts_all),
  .en_all (en_all),
  .irq    (irq)
);

// File: tb/tb_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_edge_ctrl;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_sel, bus_wr;
  logic [6:0]   bus_addr;
  logic [31:0]  bus_wdata, bus_rdata;
  logic [63:0]  pin_in, pin_out, pin_oe;
  logic [127:0] alt_sel;
  logic         irq;

  int  n_run = 0, n_fail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_edge_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .alt_sel(alt_sel), .irq(irq)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] addr, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] addr, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addr;
    #0.5;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic logic [1:0] af_val(input int n);
    return 2'((n * 3 + 1) % 4);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] out_m, ren_m, fen_m;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    for (int w = 0; w < 18; w++) begin
      rd(7'(w * 4), d);
      chk($sformatf("R12 word %0d", w), 128'(d), 128'd0);
    end
    chk("R12 pin_oe", 128'(pin_oe), 128'd0);
    chk("R12 pin_out", 128'(pin_out), 128'd0);
    chk("R12 alt_sel", alt_sel, 128'd0);
    chk("R12 irq", 128'(irq), 128'd0);

    // R2 direction
    wr(7'h08, 32'hA5A5_0F0F);
    wr(7'h0C, 32'h1234_8001);
    rd(7'h08, d); chk("R2 dir0 read", 128'(d), 128'hA5A5_0F0F);
    rd(7'h0C, d); chk("R2 dir1 read", 128'(d), 128'h1234_8001);
    chk("R2 pin_oe", 128'(pin_oe), 128'h1234_8001_A5A5_0F0F);

    // R4 set sweep, one pin per write
    out_m = '0;
    for (int n = 0; n < 64; n++) begin
      wr(7'(16 + (n / 32) * 4), 32'(1) << (n % 32));
      out_m[n] = 1'b1;
      chk($sformatf("R4 set pin %0d", n), 128'(pin_out), 128'(out_m));
    end
    // R5 clear sweep, odd pins
    for (int n = 1; n < 64; n += 2) begin
      wr(7'(24 + (n / 32) * 4), 32'(1) << (n % 32));
      out_m[n] = 1'b0;
      chk($sformatf("R5 clear pin %0d", n), 128'(pin_out), 128'(out_m));
    end
    rd(7'h10, d); chk("R1 set word reads 0", 128'(d), 128'd0);
    rd(7'h1C, d); chk("R1 clear word reads 0", 128'(d), 128'd0);

    // R1 ignored accesses
    wr(7'h00, 32'hFFFF_FFFF);
    wr(7'h49, 32'hFFFF_FFFF);
    wr(7'h09, 32'h0);
    chk("R1 ignored writes keep pin_out", 128'(pin_out), 128'(out_m));
    chk("R1 ignored writes keep pin_oe", 128'(pin_oe), 128'h1234_8001_A5A5_0F0F);
    rd(7'h0A, d); chk("R1 misaligned read 0", 128'(d), 128'd0);
    for (int w = 18; w < 32; w++) begin
      rd(7'(w * 4), d);
      chk($sformatf("R1 unmapped word %0d", w), 128'(d), 128'd0);
    end

    // R3 level readback timing
    @(negedge clk); pin_in = 64'hDEAD_BEEF_0123_4567;
    @(negedge clk);
    rd(7'h00, d); chk("R3 level not yet visible", 128'(d), 128'd0);
    @(negedge clk);
    rd(7'h00, d); chk("R3 level bank0", 128'(d), 128'h0123_4567);
    rd(7'h04, d); chk("R3 level bank1", 128'(d), 128'hDEAD_BEEF);
    chk("R7 no enables no irq", 128'(irq), 128'd0);
    @(negedge clk); pin_in = '0;
    repeat (4) @(negedge clk);

    // R6/R7 mode per pin: n%4 -> 0 none, 1 rise, 2 fall, 3 both
    ren_m = '0; fen_m = '0;
    for (int n = 0; n < 64; n++) begin
      ren_m[n] = (n % 4 == 1) || (n % 4 == 3);
      fen_m[n] = (n % 4 == 2) || (n % 4 == 3);
    end
    wr(7'h20, ren_m[31:0]); wr(7'h24, ren_m[63:32]);
    wr(7'h28, fen_m[31:0]); wr(7'h2C, fen_m[63:32]);
    @(negedge clk); pin_in = '1;
    @(negedge clk); @(negedge clk);
    rd(7'h30, d); chk("R6 status not before third edge", 128'(d), 128'd0);
    @(negedge clk);
    rd(7'h30, d); chk("R6 rising status bank0", 128'(d), 128'(ren_m[31:0]));
    rd(7'h34, d); chk("R6 rising status bank1", 128'(d), 128'(ren_m[63:32]));
    chk("R10 irq with status", 128'(irq), 128'd1);
    repeat (3) @(negedge clk);
    rd(7'h30, d); chk("R8 status held", 128'(d), 128'(ren_m[31:0]));
    wr(7'h30, 32'h0);
    rd(7'h30, d); chk("R8 write 0 no effect", 128'(d), 128'(ren_m[31:0]));
    wr(7'h30, 32'hFFFF_FFFF);
    rd(7'h30, d); chk("R8 bank0 cleared", 128'(d), 128'd0);
    chk("R10 irq held by bank1", 128'(irq), 128'd1);
    wr(7'h34, 32'hFFFF_FFFF);
    chk("R10 irq low after clear", 128'(irq), 128'd0);

    @(negedge clk); pin_in = '0;
    repeat (3) @(negedge clk);
    rd(7'h30, d); chk("R7 falling status bank0", 128'(d), 128'(fen_m[31:0]));
    rd(7'h34, d); chk("R7 falling status bank1", 128'(d), 128'(fen_m[63:32]));
    wr(7'h34, 32'h0000_FFFF);
    rd(7'h34, d); chk("R8 partial clear", 128'(d), 128'(fen_m[63:48]) << 16);
    wr(7'h30, 32'hFFFF_FFFF); wr(7'h34, 32'hFFFF_FFFF);
    chk("R10 irq low", 128'(irq), 128'd0);

    // R9 edge collides with clear on pin 3 (both edges enabled)
    @(negedge clk); pin_in[3] = 1'b1;
    repeat (3) @(negedge clk);
    rd(7'h30, d); chk("R9 pin3 set before collision", 128'(d[3]), 128'd1);
    pin_in[3] = 1'b0;
    @(negedge clk); @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 7'h30; bus_wdata = 32'h8;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(7'h30, d); chk("R9 set wins over clear", 128'(d), 128'h8);
    chk("R9 irq stays", 128'(irq), 128'd1);
    wr(7'h30, 32'h8);
    chk("R10 irq cleared", 128'(irq), 128'd0);

    // R11 alternate function map
    for (int w = 0; w < 4; w++) begin
      logic [31:0] v;
      v = '0;
      for (int k = 0; k < 16; k++) v[2*k +: 2] = af_val(w * 16 + k);
      wr(7'(56 + w * 4), v);
      rd(7'(56 + w * 4), d);
      chk($sformatf("R11 alt word %0d read", w), 128'(d), 128'(v));
    end
    for (int n = 0; n < 64; n++)
      chk($sformatf("R11 alt pin %0d", n), 128'(alt_sel[2*n +: 2]), 128'(af_val(n)));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule